// File: doc/BRIEF.md
# Direct-Mapped Data Cache Controller

This block is a direct-mapped data cache placed between a processor load/store port and a slower word-wide main-memory port. Every memory block has a single home line in the cache. Lines hold several words, and each line keeps a valid flag, a dirty flag and a stored tag. The processor port uses a request/ready handshake. The processor holds its request until `cpuReady` is high at a rising clock edge. Hits finish in the cycle of the request. A miss stalls the processor until the line has been refilled.

Two build-time switches set the policy. `WRITE_BACK` chooses write-back or write-through. `WRITE_ALLOC` chooses whether a write miss fills the line. In write-through mode, memory writes go into a small internal queue that drains on its own, so the processor does not wait for memory unless the queue is full. In write-back mode, a modified line reaches memory only when a different block takes over its line.

Top module: `dcache_direct`

## Requirements
- R1: A word address is decoded as follows. The low log2(WORDS) bits are the word offset. The next log2(LINES) bits are the line index. The remaining upper bits are the tag. Memory addresses for a line are formed as {tag, index, offset}.
- R2: A lookup hits only when the indexed line is valid and its stored tag equals the address tag. Reset clears every valid bit, so the first access to any address after reset is a miss. Reset also leaves `cpuReady` and `memReq` low while no request is pending.
- R3: A read hit raises `cpuReady` in the request cycle, returns the stored word, and starts no memory transfer. `cpuReady` is never high without `cpuReq`.
- R4: A refill performs exactly WORDS memory reads, one per `memReq`/`memReady` handshake. Offsets run from 0 upward. The requested word is then returned with the data memory held.
- R5: In write-back mode, a write hit updates only the cache, issues no memory write, and marks the line dirty.
- R6: In write-back mode, a miss on a dirty line first writes all WORDS words of the old block back to the old block's addresses, in increasing offset order, and only then starts the refill reads. A miss on a clean line performs only the refill reads.
- R7: With write-allocate, a write miss refills the line and then writes the word into it. A following read of that address hits.
- R8: With no-write-allocate, a write miss fills no line and sends the word to memory directly, through the queue in write-through mode. A later read of that address therefore misses.
- R9: In write-through mode, every completed processor write causes exactly one memory write with the same address and data. These memory writes occur in the order the processor issued them.
- R10: In write-through mode, a write completes in its request cycle while the queue has a free entry. When the queue is full, the write stalls until an entry has drained.
- R11: A refill never starts while queued writes remain. A read miss therefore always returns the most recent written value.
- R12: Under any mix of reads and writes, every read returns the value of the most recent write to that address, or the initial memory value if there has been none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor request, held until accepted |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | ADDR_W | Word address of the access |
| cpuWdata | input | DATA_W | Store data |
| cpuReady | output | 1 | Request completes at this clock edge |
| cpuRdata | output | DATA_W | Load data, valid with `cpuReady` on a load |
| memReq | output | 1 | Memory transfer request |
| memWe | output | 1 | 1 = memory write, 0 = memory read |
| memAddr | output | ADDR_W | Word address of the memory transfer |
| memWdata | output | DATA_W | Memory write data |
| memReady | input | 1 | Memory accepts the transfer at this edge |
| memRdata | input | DATA_W | Memory read data, valid with `memReady` |

## Verification
A wrong valid, tag or dirty bit shows at the ports as an unexpected memory transfer. The bad state appears as a refill on an access that should have hit, a missing or extra write-back burst, or a wrong address in a burst. All of these are visible during the very access that depends on that line. A wrong data word or a lost queue entry shows up as a bad load value only when that address is read again. It may also show as a mismatch between the memory model and the expected contents once the queue has drained. The bench therefore logs every memory handshake per access, and it re-reads addresses at random to expose stale words that lie dormant.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  typedef enum logic [1:0] {MS_BUF, MS_EVICT, MS_FILL, MS_DIRECT} memSel_e;

  typedef struct packed {
    logic    fillWord;
    logic    lineValidate;
    logic    lineClean;
    logic    cpuWrite;
    logic    bufPush;
    logic    bufPop;
    memSel_e memSel;
  } ctlStrobe_t;
endpackage

// File: rtl/dcache_datapath.sv
module dcache_datapath
  import dcache_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 32,
  parameter int LINES      = 8,
  parameter int WORDS      = 4,
  parameter int BUF_DEPTH  = 4,
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctlStrobe_t                 ctl,
  input  logic [$clog2(WORDS)-1:0]   wordIdx,
  input  logic [ADDR_W-1:0]          cpuAddr,
  input  logic [DATA_W-1:0]          cpuWdata,
  input  logic [DATA_W-1:0]          memRdata,
  output logic [DATA_W-1:0]          cpuRdata,
  output logic                       hit,
  output logic                       victimDirty,
  output logic                       bufEmpty,
  output logic                       bufFull,
  output logic [ADDR_W-1:0]          memAddr,
  output logic [DATA_W-1:0]          memWdata,
  output logic                       memWe
);
  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int PTR_W = $clog2(BUF_DEPTH);
  localparam int CNT_W = $clog2(BUF_DEPTH + 1);

  // address decode
  logic [OFF_W-1:0] offset;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  assign offset = cpuAddr[OFF_W-1:0];
  assign idx    = cpuAddr[OFF_W +: IDX_W];
  assign tag    = cpuAddr[ADDR_W-1 -: TAG_W];

  // line state and storage
  logic [LINES-1:0]  validQ, dirtyQ;
  logic [TAG_W-1:0]  tagQ  [LINES];
  logic [DATA_W-1:0] dataQ [LINES][WORDS];

  assign hit         = validQ[idx] && (tagQ[idx] == tag);
  assign victimDirty = validQ[idx] && dirtyQ[idx];
  assign cpuRdata    = dataQ[idx][offset];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      dirtyQ <= '0;
    end else begin
      if (ctl.lineClean) dirtyQ[idx] <= 1'b0;
      if (ctl.fillWord) begin
        validQ[idx] <= 1'b0;
        dirtyQ[idx] <= 1'b0;
      end
      if (ctl.lineValidate) validQ[idx] <= 1'b1;
      if (ctl.cpuWrite && WRITE_BACK) dirtyQ[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.lineValidate) tagQ[idx] <= tag;
    if (ctl.fillWord) dataQ[idx][wordIdx] <= memRdata;
    if (ctl.cpuWrite) dataQ[idx][offset] <= cpuWdata;
  end

  // write queue (used in write-through mode)
  logic [ADDR_W-1:0] bufAddrQ [BUF_DEPTH];
  logic [DATA_W-1:0] bufDataQ [BUF_DEPTH];
  logic [PTR_W-1:0]  wrPtrQ, rdPtrQ;
  logic [CNT_W-1:0]  countQ;

  assign bufEmpty = (countQ == '0);
  assign bufFull  = (countQ == CNT_W'(BUF_DEPTH));

  function automatic logic [PTR_W-1:0] ptrNext(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(BUF_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtrQ <= '0;
      rdPtrQ <= '0;
      countQ <= '0;
    end else begin
      if (ctl.bufPush) wrPtrQ <= ptrNext(wrPtrQ);
      if (ctl.bufPop)  rdPtrQ <= ptrNext(rdPtrQ);
      case ({ctl.bufPush, ctl.bufPop})
        2'b10:   countQ <= countQ + 1'b1;
        2'b01:   countQ <= countQ - 1'b1;
        default: countQ <= countQ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.bufPush) begin
      bufAddrQ[wrPtrQ] <= cpuAddr;
      bufDataQ[wrPtrQ] <= cpuWdata;
    end
  end

  // memory port mux
  always_comb begin
    case (ctl.memSel)
      MS_EVICT: begin
        memAddr  = {tagQ[idx], idx, wordIdx};
        memWdata = dataQ[idx][wordIdx];
        memWe    = 1'b1;
      end
      MS_FILL: begin
        memAddr  = {tag, idx, wordIdx};
        memWdata = '0;
        memWe    = 1'b0;
      end
      MS_DIRECT: begin
        memAddr  = cpuAddr;
        memWdata = cpuWdata;
        memWe    = 1'b1;
      end
      default: begin
        memAddr  = bufAddrQ[rdPtrQ];
        memWdata = bufDataQ[rdPtrQ];
        memWe    = 1'b1;
      end
    endcase
  end

  // R10: the control never pushes into a full queue
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.bufPush |-> (countQ < CNT_W'(BUF_DEPTH)) || ctl.bufPop);
  // R9: a queue entry is only retired when one exists
  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.bufPop |-> !bufEmpty);
  // R11: refill words are only accepted once the queue is empty
  assert_fill_drained_R11: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fillWord |-> bufEmpty);
  // R6: a dirty line is never overwritten by refill data
  assert_no_dirty_overwrite_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fillWord |-> !victimDirty);
endmodule

// File: rtl/dcache_control.sv
module dcache_control
  import dcache_pkg::*;
#(
  parameter int WORDS       = 4,
  parameter bit WRITE_BACK  = 1'b1,
  parameter bit WRITE_ALLOC = 1'b1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cpuReq,
  input  logic                     cpuWe,
  input  logic                     hit,
  input  logic                     victimDirty,
  input  logic                     bufEmpty,
  input  logic                     bufFull,
  input  logic                     memReady,
  output logic                     cpuReady,
  output logic                     memReq,
  output logic [$clog2(WORDS)-1:0] wordIdx,
  output ctlStrobe_t               ctl
);
  localparam int OFF_W = $clog2(WORDS);

  typedef enum logic [1:0] {S_LOOK, S_EVICT, S_FILL, S_DIRECT} state_e;
  state_e stateQ, stateNext;
  logic [OFF_W-1:0] cntQ, cntNext;
  logic lastWord;

  assign wordIdx  = cntQ;
  assign lastWord = (cntQ == OFF_W'(WORDS - 1));

  always_comb begin
    ctl        = '0;
    ctl.memSel = MS_BUF;
    cpuReady   = 1'b0;
    memReq     = 1'b0;
    stateNext  = stateQ;
    cntNext    = cntQ;
    case (stateQ)
      S_LOOK: begin
        memReq     = !bufEmpty;
        ctl.bufPop = !bufEmpty && memReady;
        if (cpuReq) begin
          if (hit && !cpuWe) begin
            cpuReady = 1'b1;
          end else if (hit) begin
            if (WRITE_BACK || !bufFull) begin
              ctl.cpuWrite = 1'b1;
              ctl.bufPush  = !WRITE_BACK;
              cpuReady     = 1'b1;
            end
          end else if (cpuWe && !WRITE_ALLOC) begin
            if (WRITE_BACK) begin
              stateNext = S_DIRECT;
            end else if (!bufFull) begin
              ctl.bufPush = 1'b1;
              cpuReady    = 1'b1;
            end
          end else begin
            cntNext = '0;
            if (WRITE_BACK && victimDirty) stateNext = S_EVICT;
            else if (bufEmpty)             stateNext = S_FILL;
          end
        end
      end
      S_EVICT: begin
        memReq     = 1'b1;
        ctl.memSel = MS_EVICT;
        if (memReady) begin
          cntNext = cntQ + 1'b1;
          if (lastWord) begin
            ctl.lineClean = 1'b1;
            cntNext       = '0;
            stateNext     = S_FILL;
          end
        end
      end
      S_FILL: begin
        memReq     = 1'b1;
        ctl.memSel = MS_FILL;
        if (memReady) begin
          ctl.fillWord = 1'b1;
          cntNext      = cntQ + 1'b1;
          if (lastWord) begin
            ctl.lineValidate = 1'b1;
            cntNext          = '0;
            stateNext        = S_LOOK;
          end
        end
      end
      default: begin
        memReq     = 1'b1;
        ctl.memSel = MS_DIRECT;
        if (memReady) begin
          cpuReady  = 1'b1;
          stateNext = S_LOOK;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_LOOK;
      cntQ   <= '0;
    end else begin
      stateQ <= stateNext;
      cntQ   <= cntNext;
    end
  end

  // R3: completion is only signalled for a pending request
  assert_ready_needs_req_R3: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> cpuReq);
  // R8: a direct memory write only carries a pending processor store
  assert_direct_is_store_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && ctl.memSel == MS_DIRECT) |-> (cpuReq && cpuWe));
  // R4: refill words never arrive while the processor is told it is done
  assert_fill_stalls_cpu_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fillWord |-> !cpuReady);
endmodule

// File: rtl/dcache_direct.sv
module dcache_direct
  import dcache_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 32,
  parameter int LINES       = 8,
  parameter int WORDS       = 4,
  parameter int BUF_DEPTH   = 4,
  parameter bit WRITE_BACK  = 1'b1,
  parameter bit WRITE_ALLOC = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRdata
);
  localparam int OFF_W = $clog2(WORDS);

  ctlStrobe_t       ctl;
  logic [OFF_W-1:0] wordIdx;
  logic             hit, victimDirty, bufEmpty, bufFull;

  dcache_control #(
    .WORDS(WORDS), .WRITE_BACK(WRITE_BACK), .WRITE_ALLOC(WRITE_ALLOC)
  ) u_control (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .hit(hit),
    .victimDirty(victimDirty), .bufEmpty(bufEmpty), .bufFull(bufFull),
    .memReady(memReady), .cpuReady(cpuReady), .memReq(memReq),
    .wordIdx(wordIdx), .ctl(ctl)
  );

  dcache_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS),
    .BUF_DEPTH(BUF_DEPTH), .WRITE_BACK(WRITE_BACK)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wordIdx(wordIdx), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .memRdata(memRdata), .cpuRdata(cpuRdata), .hit(hit),
    .victimDirty(victimDirty), .bufEmpty(bufEmpty), .bufFull(bufFull),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe)
  );
endmodule

// File: tb/test_dcache_direct.sv
module test_dcache_direct;
  localparam int PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int MEMSZ = 1 << AW;
  localparam int LOGSZ = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  // index 0: write-back + allocate, index 1: write-through + no-allocate
  logic          cpuReq [2], cpuWe [2], cpuReady [2];
  logic [AW-1:0] cpuAddr [2];
  logic [DW-1:0] cpuWdata [2], cpuRdata [2];
  logic          memReq [2], memWe [2], memReady [2];
  logic [AW-1:0] memAddr [2];
  logic [DW-1:0] memWdata [2], memRdata [2];
  logic          memEn [2];

  logic [DW-1:0] memModel [2][MEMSZ];
  logic [DW-1:0] refMem [2][MEMSZ];
  logic [AW-1:0] logAddr [2][LOGSZ];
  logic          logWe [2][LOGSZ];
  logic [DW-1:0] logData [2][LOGSZ];
  int            logN [2];

  int tests = 0;
  int fails = 0;

  dcache_direct i_dcache_direct (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq[0]), .cpuWe(cpuWe[0]),
    .cpuAddr(cpuAddr[0]), .cpuWdata(cpuWdata[0]), .cpuReady(cpuReady[0]),
    .cpuRdata(cpuRdata[0]), .memReq(memReq[0]), .memWe(memWe[0]),
    .memAddr(memAddr[0]), .memWdata(memWdata[0]), .memReady(memReady[0]),
    .memRdata(memRdata[0])
  );

  dcache_direct #(.WRITE_BACK(1'b0), .WRITE_ALLOC(1'b0)) i_dcache_direct_wt (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq[1]), .cpuWe(cpuWe[1]),
    .cpuAddr(cpuAddr[1]), .cpuWdata(cpuWdata[1]), .cpuReady(cpuReady[1]),
    .cpuRdata(cpuRdata[1]), .memReq(memReq[1]), .memWe(memWe[1]),
    .memAddr(memAddr[1]), .memWdata(memWdata[1]), .memReady(memReady[1]),
    .memRdata(memRdata[1])
  );

  function automatic logic [DW-1:0] initVal(input int a);
    return 32'hC0DE0000 ^ (a * 32'h00010101);
  endfunction

  function automatic logic [AW-1:0] lineBase(input logic [AW-1:0] a);
    return a & ~AW'(3);
  endfunction

  // memory model: combinational read data, writes and log at the edge
  always_comb begin
    for (int s = 0; s < 2; s++) memRdata[s] = memModel[s][memAddr[s]];
  end

  always @(posedge clk) begin
    for (int s = 0; s < 2; s++) begin
      if (!rstN) begin
        for (int a = 0; a < MEMSZ; a++) memModel[s][a] <= initVal(a);
        logN[s] <= 0;
      end else if (memReq[s] && memReady[s]) begin
        if (memWe[s]) memModel[s][memAddr[s]] <= memWdata[s];
        logAddr[s][logN[s] % LOGSZ] <= memAddr[s];
        logWe[s][logN[s] % LOGSZ]   <= memWe[s];
        logData[s][logN[s] % LOGSZ] <= memWdata[s];
        logN[s] <= logN[s] + 1;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      for (int s = 0; s < 2; s++) memReady[s] = memEn[s] && (($urandom % 4) != 0);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic access(input int s, input bit we, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, output logic [DW-1:0] rd,
                        output int cycles, output int logStart);
    @(negedge clk);
    logStart    = logN[s];
    cpuReq[s]   = 1'b1;
    cpuWe[s]    = we;
    cpuAddr[s]  = a;
    cpuWdata[s] = d;
    cycles      = 0;
    forever begin
      #(PERIOD/4);
      if (cpuReady[s]) break;
      @(negedge clk);
      cycles++;
    end
    rd = cpuRdata[s];
    @(posedge clk);
    #1;
    cpuReq[s] = 1'b0;
    if (we) refMem[s][a] = d;
  endtask

  // checks WORDS consecutive log entries of one kind over one line
  function automatic bit burstOk(input int s, input int start, input bit we,
                                 input logic [AW-1:0] base);
    for (int k = 0; k < 4; k++) begin
      if (logWe[s][(start + k) % LOGSZ] != we) return 1'b0;
      if (logAddr[s][(start + k) % LOGSZ] != base + AW'(k)) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic drain(input int s);
    memEn[s] = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    finishRun();
  end

  initial begin
    logic [DW-1:0] rd;
    int cyc, st, n;
    void'($urandom(32'd20240607));
    for (int s = 0; s < 2; s++) begin
      cpuReq[s] = 1'b0; cpuWe[s] = 1'b0; cpuAddr[s] = '0; cpuWdata[s] = '0;
      memEn[s] = 1'b1; memReady[s] = 1'b0;
      for (int a = 0; a < MEMSZ; a++) refMem[s][a] = initVal(a);
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #(PERIOD/4);
    // R2: quiet after reset
    check(!cpuReady[0] && !memReq[0] && !cpuReady[1] && !memReq[1], "R2",
          "idle outputs after reset", {cpuReady[0], memReq[0], cpuReady[1], memReq[1]}, 0);

    // ---------------- write-back, allocate ----------------
    access(0, 1'b0, 10'h012, '0, rd, cyc, st);
    n = logN[0] - st;
    check(n == 4 && burstOk(0, st, 1'b0, 10'h010), "R2",
          "first access misses and refills", n, 4);
    check(rd == initVal(10'h012), "R4", "refill read data", rd, initVal(10'h012));
    access(0, 1'b0, 10'h013, '0, rd, cyc, st);
    n = logN[0] - st;
    check(n == 0 && cyc == 0 && rd == initVal(10'h013), "R3",
          "read hit same cycle, no memory", rd, initVal(10'h013));
    access(0, 1'b1, 10'h011, 32'h1111_AAAA, rd, cyc, st);
    n = logN[0] - st;
    check(n == 0 && cyc == 0, "R5", "write hit stays in cache", n, 0);
    access(0, 1'b0, 10'h014, '0, rd, cyc, st);
    n = logN[0] - st;
    check(n == 4 && burstOk(0, st, 1'b0, 10'h014), "R1",
          "next index refills own line only", n, 4);
    access(0, 1'b0, 10'h031, '0, rd, cyc, st);
    n = logN[0] - st;
    check(n == 8 && burstOk(0, st, 1'b1, 10'h010) && burstOk(0, st + 4, 1'b0, 10'h030),
          "R6", "dirty eviction before refill, same index other tag (R1)", n, 8);
    check(logData[0][(st + 1) % LOGSZ] == 32'h1111_AAAA, "R6", "written-back word",
          logData[0][(st + 1) % LOGSZ], 32'h1111_AAAA);
    check(rd == initVal(10'h031), "R4", "data after eviction", rd, initVal(10'h031));
    access(0, 1'b0, 10'h011, '0, rd, cyc, st);
    n = logN[0] - st;
    check(n == 4 && burstOk(0, st, 1'b0, 10'h010), "R6", "clean victim not written", n, 4);
    check(rd == 32'h1111_AAAA, "R12", "value survives eviction", rd, 32'h1111_AAAA);
    access(0, 1'b1, 10'h2A1, 32'h2222_BBBB, rd, cyc, st);
    n = logN[0] - st;
    check(n == 4 && burstOk(0, st, 1'b0, lineBase(10'h2A1)), "R7",
          "write miss allocates", n, 4);
    access(0, 1'b0, 10'h2A1, '0, rd, cyc, st);
    n = logN[0] - st;
    check(n == 0 && rd == 32'h2222_BBBB, "R7", "read after allocated write hits",
          rd, 32'h2222_BBBB);

    // ---------------- write-through, no-allocate ----------------
    access(1, 1'b1, 10'h040, 32'h4040_0001, rd, cyc, st);
    check(cyc == 0, "R10", "buffered write completes at once", cyc, 0);
    drain(1);
    n = logN[1] - st;
    check(n == 1 && logWe[1][st % LOGSZ] && logAddr[1][st % LOGSZ] == 10'h040 &&
          memModel[1][10'h040] == 32'h4040_0001, "R8", "no-allocate write goes to memory only",
          n, 1);
    access(1, 1'b0, 10'h040, '0, rd, cyc, st);
    n = logN[1] - st;
    check(n == 4 && burstOk(1, st, 1'b0, 10'h040) && rd == 32'h4040_0001, "R8",
          "read after no-allocate write misses", rd, 32'h4040_0001);
    access(1, 1'b1, 10'h041, 32'h4141_0002, rd, cyc, st);
    drain(1);
    n = logN[1] - st;
    check(n == 1 && logAddr[1][st % LOGSZ] == 10'h041 &&
          logData[1][st % LOGSZ] == 32'h4141_0002, "R9", "write hit also writes memory",
          logData[1][st % LOGSZ], 32'h4141_0002);

    // R10: full queue stalls the fifth write
    memEn[1] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    n = 0;
    for (int k = 0; k < 4; k++) begin
      access(1, 1'b1, 10'h100 + AW'(k), 32'h5000_0000 + k, rd, cyc, st);
      n += cyc;
    end
    check(n == 0, "R10", "writes complete while queue has room", n, 0);
    fork
      access(1, 1'b1, 10'h104, 32'h5000_0004, rd, cyc, st);
      begin
        repeat (4) @(negedge clk);
        #(PERIOD/4);
        check(!cpuReady[1], "R10", "full queue stalls write", cpuReady[1], 0);
        memEn[1] = 1'b1;
      end
    join
    check(cyc >= 4, "R10", "stall length", cyc, 4);
    drain(1);
    n = 0;
    for (int k = 0; k < 5; k++)
      if (logWe[1][(logN[1] - 5 + k) % LOGSZ] && logAddr[1][(logN[1] - 5 + k) % LOGSZ] == 10'h100 + AW'(k))
        n++;
    check(n == 5, "R9", "memory writes in issue order", n, 5);

    // R11: read miss waits for queued write to the same address
    memEn[1] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    access(1, 1'b1, 10'h080, 32'h8080_0003, rd, cyc, st);
    fork
      access(1, 1'b0, 10'h080, '0, rd, cyc, n);
      begin
        repeat (4) @(negedge clk);
        memEn[1] = 1'b1;
      end
    join
    check(rd == 32'h8080_0003 && cyc >= 4, "R11", "read miss sees queued data",
          rd, 32'h8080_0003);
    check(logWe[1][st % LOGSZ] && burstOk(1, st + 1, 1'b0, 10'h080), "R11",
          "queued write precedes refill", logAddr[1][st % LOGSZ], 10'h080);

    // R12: random mix on both policies
    for (int s = 0; s < 2; s++) begin
      n = 0;
      for (int k = 0; k < 400; k++) begin
        logic [AW-1:0] a;
        logic [DW-1:0] exp;
        bit we;
        a   = AW'($urandom % 128);
        we  = ($urandom % 5) < 2;
        exp = refMem[s][a];
        access(s, we, a, $urandom, rd, cyc, st);
        if (!we && rd !== exp) begin
          n++;
          check(1'b0, "R12", "random read", rd, exp);
        end
      end
      check(n == 0, "R12", "random read mismatches", n, 0);
    end
    drain(1);
    n = 0;
    for (int a = 0; a < MEMSZ; a++) if (memModel[1][a] !== refMem[1][a]) n++;
    check(n == 0, "R9", "memory matches after write-through drain", n, 0);
    finishRun();
  end
endmodule